// File: doc/BRIEF.md
# Leveled Prioritized Interrupt Controller

This block gathers a bank of interrupt request lines and presents the processor with the single most urgent pending request. The result is a 3-bit urgency level and an 8-bit vector number. The seven lowest-numbered lines are external inputs. Each of them has a fixed level and a fixed priority. Every other line is an internal source, and software sets its level (1 to 7) and its priority within that level through a small register write port.

Each source can be masked on its own. A global mask-all bit silences the whole block at once. The processor acknowledges by naming a level. One cycle later the block returns the vector of the best pending source at that level, or a spurious vector if that level has nothing pending. A hardware acknowledge cycle and a software acknowledge both use this path.

A wake-up output is computed with no clock in its path. It lets a stopped clock domain be restarted by any request that is unmasked and enabled.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, irq_level and irq_vector are 0, wake and ack_valid are 0, every source is masked, mask-all is clear and every internal source has level 0.
- R2: A write to cfg_addr = n, for source n, stores cfg_wdata[2:0] as the priority, cfg_wdata[5:3] as the level and cfg_wdata[6] as the mask bit (1 = masked). An internal source whose level is 0 is disabled and never wins.
- R3: Among eligible sources, the one with the highest level wins. Eligible means pending, unmasked, level non-zero and mask-all clear. irq_level shows the winner's level.
- R4: Among eligible sources of equal level, the higher priority value wins. If level and priority are both equal, the lower source index wins.
- R5: irq_vector is 64 plus the index of the winning source. When no source is eligible, irq_level and irq_vector are both 0.
- R6: External sources 0 to 6 have fixed level index+1 and fixed priority 7. A write to one of them changes only its mask bit.
- R7: A source whose mask bit is 1 never wins and never drives wake.
- R8: A write to cfg_addr = NUM_SRC sets mask-all from cfg_wdata[0]. While mask-all is set, irq_level is 0 and wake is 0.
- R9: When ack_req is high at a clock edge, ack_valid is 1 after that edge. ack_vector then holds the vector of the best eligible source whose level equals ack_lvl, or 24 if there is none. When ack_req is low, ack_valid is 0 after the edge.
- R10: wake is a purely combinational OR over the raw irq_in lines of the sources that are unmasked and enabled, gated by mask-all. It changes without any clock edge.
- R11: irq_in is registered once. A change on irq_in reaches irq_level and irq_vector after one clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_SRC | Request lines, level sensitive |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW | Source index, or NUM_SRC for mask-all |
| cfg_wdata | input | 7 | {mask, level[2:0], priority[2:0]} |
| ack_req | input | 1 | Acknowledge request |
| ack_lvl | input | 3 | Level being acknowledged |
| ack_valid | output | 1 | Acknowledge response valid |
| ack_vector | output | 8 | Acknowledged vector, or 24 if spurious |
| irq_level | output | 3 | Level of the current winner, 0 if none |
| irq_vector | output | 8 | Vector of the current winner, 0 if none |
| wake | output | 1 | Combinational wake-up request |

## Verification
On every cycle the assertions check four things:
- the winner picked by each arbiter is really pending and unmasked;
- the vector output stays within its range and is 0 exactly when the level is 0;
- mask-all silences both the level and wake;
- an acknowledge response follows its request by exactly one edge.

The assertions cannot show which source should have won. Only the bench scenarios can show that: level ordering, priority ties resolved by index, the frozen external settings, the disabling effect of level 0, and the spurious acknowledge at an empty level. The bench compares each of these against its own model of the configuration. It also checks that wake responds before any clock edge.

// File: rtl/lvl_irq_pkg.sv
`timescale 1ns/1ps
package lvl_irq_pkg;
  localparam logic [7:0] VEC_BASE     = 8'd64;
  localparam logic [7:0] VEC_SPURIOUS = 8'd24;
  localparam logic [2:0] EXT_PRI      = 3'd7;

  typedef struct packed {
    logic       msk;
    logic [2:0] lvl;
    logic [2:0] pri;
  } src_cfg_t;

  // ordering key: level first, then priority
  function automatic logic [5:0] rank_of(src_cfg_t c);
    return {c.lvl, c.pri};
  endfunction

  function automatic logic [7:0] vector_of(int unsigned idx);
    return VEC_BASE + 8'(idx);
  endfunction

  function automatic logic usable(src_cfg_t c);
    return !c.msk && (c.lvl != 3'd0);
  endfunction
endpackage

// File: rtl/lvl_irq_cfg.sv
`timescale 1ns/1ps
module lvl_irq_cfg
  import lvl_irq_pkg::*;
#(
  parameter int NUM_SRC = 63,
  parameter int NUM_EXT = 7,
  parameter int AW      = $clog2(NUM_SRC + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            addr,
  input  logic [6:0]               wdata,
  output src_cfg_t [NUM_SRC-1:0]   cfg_o,
  output logic                     mask_all
);
  localparam logic [AW-1:0] ALL_ADDR = AW'(NUM_SRC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        mask_all <= 1'b0;
    else if (we && addr == ALL_ADDR)   mask_all <= wdata[0];
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic hit;
    assign hit = we && (addr == AW'(g));
    if (g < NUM_EXT) begin : g_ext
      logic msk_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   msk_q <= 1'b1;
        else if (hit) msk_q <= wdata[6];
      end
      assign cfg_o[g] = '{msk: msk_q, lvl: 3'(g + 1), pri: EXT_PRI};
    end else begin : g_int
      src_cfg_t reg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   reg_q <= '{msk: 1'b1, lvl: 3'd0, pri: 3'd0};
        else if (hit) reg_q <= src_cfg_t'(wdata);
      end
      assign cfg_o[g] = reg_q;

      // R2
      cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cfg_o[g] == src_cfg_t'($past(wdata))));
    end
  end
endmodule

// File: rtl/lvl_irq_pick.sv
`timescale 1ns/1ps
module lvl_irq_pick
  import lvl_irq_pkg::*;
#(
  parameter int NUM_SRC = 63,
  parameter int IW      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  src_cfg_t [NUM_SRC-1:0] cfg,
  input  logic [NUM_SRC-1:0]     req,
  input  logic                   flt_en,
  input  logic [2:0]             flt_lvl,
  output logic                   found,
  output logic [IW-1:0]          win_idx,
  output logic [2:0]             win_lvl
);
  logic [5:0] best_rank;

  // strict compare in ascending order: the lower index keeps a tie
  always_comb begin
    found     = 1'b0;
    win_idx   = '0;
    best_rank = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && usable(cfg[i]) && (!flt_en || cfg[i].lvl == flt_lvl)) begin
        if (!found || rank_of(cfg[i]) > best_rank) begin
          found     = 1'b1;
          win_idx   = IW'(i);
          best_rank = rank_of(cfg[i]);
        end
      end
    end
    win_lvl = found ? best_rank[5:3] : 3'd0;
  end

  // R3
  win_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (req[win_idx] && !cfg[win_idx].msk && cfg[win_idx].lvl != 3'd0));
  // R9
  win_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (found && flt_en) |-> (cfg[win_idx].lvl == flt_lvl));
endmodule

// File: rtl/lvl_irq_ctrl.sv
`timescale 1ns/1ps
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter int NUM_SRC = 63,
  parameter int NUM_EXT = 7,
  parameter int AW      = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               cfg_we,
  input  logic [AW-1:0]      cfg_addr,
  input  logic [6:0]         cfg_wdata,
  input  logic               ack_req,
  input  logic [2:0]         ack_lvl,
  output logic               ack_valid,
  output logic [7:0]         ack_vector,
  output logic [2:0]         irq_level,
  output logic [7:0]         irq_vector,
  output logic               wake
);
  localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  src_cfg_t [NUM_SRC-1:0] cfg;
  logic                   mask_all;
  logic [NUM_SRC-1:0]     pend_q, req_eff;
  logic                   main_found, ack_found;
  logic [IW-1:0]          main_idx, ack_idx;
  logic [2:0]             main_lvl, ack_win_lvl;

  lvl_irq_cfg #(.NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT), .AW(AW)) cfg_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .cfg_o(cfg), .mask_all(mask_all));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= irq_in;
  end

  assign req_eff = mask_all ? '0 : pend_q;

  lvl_irq_pick #(.NUM_SRC(NUM_SRC), .IW(IW)) main_pick_i (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .req(req_eff),
    .flt_en(1'b0), .flt_lvl(3'd0),
    .found(main_found), .win_idx(main_idx), .win_lvl(main_lvl));

  lvl_irq_pick #(.NUM_SRC(NUM_SRC), .IW(IW)) ack_pick_i (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .req(req_eff),
    .flt_en(1'b1), .flt_lvl(ack_lvl),
    .found(ack_found), .win_idx(ack_idx), .win_lvl(ack_win_lvl));

  assign irq_level  = main_lvl;
  assign irq_vector = main_found ? vector_of(32'(main_idx)) : 8'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid  <= 1'b0;
      ack_vector <= 8'd0;
    end else begin
      ack_valid <= ack_req;
      if (ack_req)
        ack_vector <= ack_found ? vector_of(32'(ack_idx)) : VEC_SPURIOUS;
    end
  end

  // clockless wake path from the raw request lines
  always_comb begin
    wake = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (irq_in[i] && usable(cfg[i])) wake = 1'b1;
    if (mask_all) wake = 1'b0;
  end

  // R5
  vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == 3'd0) == (irq_vector == 8'd0));
  // R5
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != 3'd0) |-> (irq_vector >= VEC_BASE && irq_vector < VEC_BASE + 8'(NUM_SRC)));
  // R8
  mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_all |-> (irq_level == 3'd0 && !wake));
  // R9
  ack_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> ack_valid);
  // R9
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_req |=> !ack_valid);
endmodule

// File: tb/lvl_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_tb_top;
  localparam int N  = 63;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [6:0]    cfg_wdata = '0;
  logic          ack_req = 1'b0;
  logic [2:0]    ack_lvl = '0;
  logic          ack_valid, wake;
  logic [7:0]    ack_vector, irq_vector;
  logic [2:0]    irq_level;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int m_lvl [N];
  int m_pri [N];
  bit m_msk [N];
  bit m_all;

  always #2.5 clk = ~clk;

  lvl_irq_ctrl #(.NUM_SRC(N), .NUM_EXT(7), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .ack_req(ack_req),
    .ack_lvl(ack_lvl), .ack_valid(ack_valid), .ack_vector(ack_vector),
    .irq_level(irq_level), .irq_vector(irq_vector), .wake(wake));

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // model: scan from the top index down, >= lets the lower index take ties
  function automatic int model_best(logic [N-1:0] rq, int flt);
    int b = -1;
    int bs = -1;
    if (m_all) return -1;
    for (int i = N - 1; i >= 0; i--) begin
      if (rq[i] && !m_msk[i] && m_lvl[i] != 0 && (flt < 0 || m_lvl[i] == flt)) begin
        int s = m_lvl[i] * 8 + m_pri[i];
        if (s >= bs) begin bs = s; b = i; end
      end
    end
    return b;
  endfunction

  task automatic wr(int addr, bit msk, int lvl, int pri);
    cfg_we = 1'b1; cfg_addr = AW'(addr);
    cfg_wdata = {msk, 3'(lvl), 3'(pri)};
    if (addr == N) m_all = pri[0];
    else begin
      m_msk[addr] = msk;
      if (addr >= 7) begin m_lvl[addr] = lvl; m_pri[addr] = pri; end
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_irq(logic [N-1:0] v);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic check_out(string tag);
    int b = model_best(irq_in, -1);
    check({tag, " level"}, int'(irq_level), b < 0 ? 0 : m_lvl[b]);
    check({tag, " vector"}, int'(irq_vector), b < 0 ? 0 : 64 + b);
  endtask

  function automatic logic [N-1:0] bits(int a, int b = -1, int c = -1);
    logic [N-1:0] v = '0;
    v[a] = 1'b1;
    if (b >= 0) v[b] = 1'b1;
    if (c >= 0) v[c] = 1'b1;
    return v;
  endfunction

  task automatic t_reset;
    check("R1 level", int'(irq_level), 0);
    check("R1 vector", int'(irq_vector), 0);
    check("R1 wake", int'(wake), 0);
    check("R1 ack_valid", int'(ack_valid), 0);
    set_irq(bits(3, 40));
    check("R1 all masked level", int'(irq_level), 0);
    set_irq('0);
  endtask

  task automatic t_levels;
    wr(10, 0, 3, 2);
    wr(20, 0, 5, 1);
    set_irq(bits(10, 20));
    check_out("R3 two levels");
    check("R3 vector 84", int'(irq_vector), 84);
    set_irq(bits(10));
    check("R2 stored level", int'(irq_level), 3);
    check_out("R3 single");
    set_irq('0);
    check_out("R5 none pending");
  endtask

  task automatic t_priority;
    wr(30, 0, 5, 6);
    wr(31, 0, 5, 6);
    wr(25, 0, 5, 3);
    set_irq(bits(25, 31, 30));
    check("R4 tie lower index", int'(irq_vector), 94);
    set_irq(bits(25, 31));
    check("R4 higher priority", int'(irq_vector), 95);
    check_out("R4 model");
    set_irq('0);
  endtask

  task automatic t_level_zero;
    wr(30, 0, 0, 6);
    irq_in = bits(30);
    #1 check("R2 level0 no wake", int'(wake), 0);
    @(negedge clk);
    check("R2 level0 disabled", int'(irq_level), 0);
    check("R5 empty vector", int'(irq_vector), 0);
    set_irq('0);
  endtask

  task automatic t_external;
    wr(2, 0, 1, 0);
    wr(6, 0, 1, 0);
    set_irq(bits(2, 10));
    check("R6 external level fixed", int'(irq_level), 3);
    check("R6 external beats equal level", int'(irq_vector), 66);
    set_irq(bits(6, 20, 2));
    check("R6 external level 7", int'(irq_level), 7);
    check("R6 vector 70", int'(irq_vector), 70);
    set_irq('0);
  endtask

  task automatic t_mask;
    wr(20, 1, 5, 1);
    set_irq(bits(20, 10));
    check("R7 masked loses", int'(irq_vector), 74);
    set_irq(bits(20));
    check("R7 masked only", int'(irq_level), 0);
    check("R7 masked no wake", int'(wake), 0);
    set_irq('0);
  endtask

  task automatic t_mask_all;
    wr(N, 0, 0, 1);
    set_irq(bits(6, 10, 31));
    check("R8 mask-all level", int'(irq_level), 0);
    check("R8 mask-all wake", int'(wake), 0);
    wr(N, 0, 0, 0);
    check("R8 released", int'(irq_vector), 70);
    set_irq('0);
  endtask

  task automatic t_ack;
    set_irq(bits(10, 31));
    ack_req = 1'b1; ack_lvl = 3'd3;
    @(negedge clk);
    check("R9 valid", int'(ack_valid), 1);
    check("R9 level3 vector", int'(ack_vector), 74);
    ack_lvl = 3'd5;
    @(negedge clk);
    check("R9 level5 vector", int'(ack_vector), 64 + model_best(irq_in, 5));
    ack_lvl = 3'd2;
    @(negedge clk);
    check("R9 spurious", int'(ack_vector), 24);
    ack_req = 1'b0;
    @(negedge clk);
    check("R9 idle", int'(ack_valid), 0);
    set_irq('0);
  endtask

  task automatic t_wake_latency;
    irq_in = bits(10);
    #1;
    check("R10 wake without edge", int'(wake), 1);
    check("R11 not yet registered", int'(irq_level), 0);
    @(negedge clk);
    check("R11 after one edge", int'(irq_level), 3);
    irq_in = '0;
    #1;
    check("R10 wake falls", int'(wake), 0);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_lvl[i] = (i < 7) ? i + 1 : 0;
      m_pri[i] = (i < 7) ? 7 : 0;
      m_msk[i] = 1'b1;
    end
    m_all = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_levels();
    t_priority();
    t_level_zero();
    t_external();
    t_mask();
    t_mask_all();
    t_ack();
    t_wake_latency();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule